// File: doc/BRIEF.md
# Coherence Probe Responder

This block lives inside a private data cache and answers coherence probes sent down by the next cache level. Each probe carries a flavour, a permission ceiling and a line address. The block reads that line's permission and dirty bit from the cache metadata. From those values it works out whether the line has to give up permission, and whether the acknowledgement must carry the line's data. It then sends that acknowledgement and writes the reduced permission back into the metadata.

Most responders return data only when the line is dirty. In this block the choice also depends on a static hierarchy-policy input. In inclusive mode the next level keeps its own copy, so clean lines are answered without data. In exclusive mode the next level holds no copy. Exclusive mode therefore returns data for a block-flavoured probe that takes permission away, and for a clean owned line that is being invalidated, so that memory is never read again for a line a cache already held. A data acknowledgement carries the whole line as a burst of beats read from a synchronous data port. The block handles one probe at a time and refuses new probes until the metadata has been updated.

Top module: `prb_resp`

## Requirements
- R1: With `cfg_exclusive`=0, a probe that lowers the permission of a dirty line is answered with data (`ack_has_data`=1), and one that lowers a clean line is answered without data, whatever the probe flavour. Permission codes: 0 none, 1 shared, 2 owned. Flavour codes: 0 plain, 1 block, 2 perm-only.
- R2: With `cfg_exclusive`=1, a block-flavoured probe (flavour 1) that lowers a line's permission is answered with data even when the line is clean.
- R3: With `cfg_exclusive`=1, a clean line that drops from owned (2) to none (0) is answered with data under every probe flavour.
- R4: With `cfg_exclusive`=1, plain and perm-only probes on a line that does not fall under R3 return data only if the line is dirty.
- R5: A probe that misses (the line's permission is 0), or whose ceiling is at or above the line's permission, is answered without data and leaves the metadata unwritten.
- R6: Every acknowledgement reports the permission before the probe on `ack_old_perm` and the permission after it on `ack_new_perm`. The new permission is the ceiling when the ceiling is below the old permission, and otherwise the old permission.
- R7: A data acknowledgement sends BEATS beats in order. Beat i carries the data port's word at address {line, i}. `ack_last` is set only on the final beat. Each beat holds steady while `ack_ready` is low. A dataless acknowledgement is one beat with `ack_last`=1.
- R8: When the permission is lowered, the metadata write (`meta_wr_en`) appears exactly one cycle after the final beat is accepted. It carries the probed line address and the new permission.
- R9: The written dirty bit is 0 whenever data was returned or the new permission is none.
- R10: From acceptance of a probe until its metadata-write cycle has passed, `prb_ready` is low, `busy` is high and no metadata read is issued. A probe held on the input is taken afterwards and sees the updated metadata.
- R11: After reset the block is idle: `prb_ready`=1, `busy`=0, `ack_valid`=0, `meta_wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_exclusive | input | 1 | Static policy: 1 exclusive hierarchy, 0 inclusive |
| prb_valid | input | 1 | Probe offered |
| prb_ready | output | 1 | Probe accepted this cycle when high with prb_valid |
| prb_kind | input | 2 | Probe flavour: 0 plain, 1 block, 2 perm-only |
| prb_cap | input | 2 | Permission ceiling after the probe |
| prb_addr | input | ADDR_W | Line address |
| busy | output | 1 | A probe is being answered |
| meta_rd_en | output | 1 | Metadata read strobe |
| meta_rd_addr | output | ADDR_W | Metadata read address |
| meta_rd_perm | input | 2 | Permission read, one cycle after the strobe |
| meta_rd_dirty | input | 1 | Dirty bit read, one cycle after the strobe |
| data_rd_en | output | 1 | Data read strobe |
| data_rd_addr | output | ADDR_W+BEAT_W | Data read address {line, beat} |
| data_rd_data | input | DATA_W | Data word, one cycle after the strobe |
| ack_valid | output | 1 | Acknowledgement beat valid |
| ack_ready | input | 1 | Acknowledgement beat accepted |
| ack_has_data | output | 1 | Beat belongs to a data-carrying acknowledgement |
| ack_last | output | 1 | Final beat |
| ack_old_perm | output | 2 | Permission before the probe |
| ack_new_perm | output | 2 | Permission after the probe |
| ack_addr | output | ADDR_W | Probed line address |
| ack_data | output | DATA_W | Beat data (0 when dataless) |
| meta_wr_en | output | 1 | Metadata write strobe |
| meta_wr_addr | output | ADDR_W | Metadata write address |
| meta_wr_perm | output | 2 | Permission written |
| meta_wr_dirty | output | 1 | Dirty bit written |

## Verification
The bench targets the cases where the two policies disagree. These are a clean owned line invalidated by a plain or perm-only probe, and a clean line lowered by a block-flavoured probe. A responder keyed only on the dirty bit would answer those without data in exclusive mode. One that ignored the flavour would also return data for a clean owned line lowered to shared. Probes that miss or that do not lower the permission check that no data and no metadata write leak out. Random-length stalls on `ack_ready` check that beats are neither skipped nor altered, and that the metadata write waits for the final beat. A second probe held on the input while the first is answered must not be looked up early. It must see the downgraded state once it is taken.

// File: rtl/prb_pkg.sv
package prb_pkg;

    typedef enum logic [1:0] {
        PERM_NONE   = 2'd0,
        PERM_SHARED = 2'd1,
        PERM_OWNED  = 2'd2,
        PERM_RSVD   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        PRB_PLAIN = 2'd0,
        PRB_BLOCK = 2'd1,
        PRB_PERM  = 2'd2,
        PRB_RSVD  = 2'd3
    } prb_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_SEND,
        ST_ACK,
        ST_DONE
    } st_e;

    // Outcome of one probe, latched for the whole response.
    typedef struct packed {
        logic  has_data;
        logic  wr;
        perm_e old_perm;
        perm_e new_perm;
        logic  new_dirty;
    } verdict_t;

    function automatic perm_e shrink_to(perm_e cur, perm_e cap);
        return (cap < cur) ? cap : cur;
    endfunction

endpackage

// File: rtl/prb_policy.sv
module prb_policy
    import prb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      excl,
    input  prb_kind_e kind,
    input  perm_e     cap,
    input  perm_e     cur_perm,
    input  logic      cur_dirty,
    output verdict_t  vd
);

    logic hit;
    logic lowers;
    logic excl_block;
    logic excl_evict;
    logic need_data;
    perm_e next_perm;

    always_comb begin
        hit        = (cur_perm != PERM_NONE);
        lowers     = hit && (cap < cur_perm);
        next_perm  = lowers ? shrink_to(cur_perm, cap) : cur_perm;
        excl_block = excl && (kind == PRB_BLOCK);
        excl_evict = excl && (cur_perm == PERM_OWNED) && (cap == PERM_NONE);
        need_data  = lowers && (cur_dirty || excl_block || excl_evict);

        vd.has_data  = need_data;
        vd.wr        = lowers;
        vd.old_perm  = cur_perm;
        vd.new_perm  = next_perm;
        vd.new_dirty = (need_data || next_perm == PERM_NONE) ? 1'b0 : cur_dirty;
    end

    // R5: a miss never produces a data response
    a_r5_miss_dataless: assert property (@(posedge clk) disable iff (rst)
        (cur_perm == PERM_NONE) |-> !vd.has_data);

    // R6: a probe never raises permission
    a_r6_no_upgrade: assert property (@(posedge clk) disable iff (rst)
        vd.new_perm <= cur_perm);

endmodule

// File: rtl/prb_seq.sv
module prb_seq
    import prb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BEATS  = 4,
    parameter int DATA_W = 32,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prb_valid,
    output logic                     prb_ready,
    input  prb_kind_e                prb_kind,
    input  perm_e                    prb_cap,
    input  logic [ADDR_W-1:0]        prb_addr,
    output logic                     busy,
    output logic                     meta_rd_en,
    output logic [ADDR_W-1:0]        meta_rd_addr,
    output prb_kind_e                kind_q,
    output perm_e                    cap_q,
    input  verdict_t                 vd,
    output logic                     data_rd_en,
    output logic [ADDR_W+BEAT_W-1:0] data_rd_addr,
    input  logic [DATA_W-1:0]        data_rd_data,
    output logic                     ack_valid,
    input  logic                     ack_ready,
    output logic                     ack_has_data,
    output logic                     ack_last,
    output perm_e                    ack_old_perm,
    output perm_e                    ack_new_perm,
    output logic [ADDR_W-1:0]        ack_addr,
    output logic [DATA_W-1:0]        ack_data,
    output logic                     meta_wr_en,
    output logic [ADDR_W-1:0]        meta_wr_addr,
    output perm_e                    meta_wr_perm,
    output logic                     meta_wr_dirty
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    st_e                st;
    logic [ADDR_W-1:0]  addr_q;
    verdict_t           vd_q;
    logic [BEAT_W-1:0]  beat_q;
    logic [DATA_W-1:0]  data_q;
    logic               at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            kind_q <= PRB_PLAIN;
            cap_q  <= PERM_NONE;
            addr_q <= '0;
            vd_q   <= '0;
            beat_q <= '0;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (prb_valid) begin
                    kind_q <= prb_kind;
                    cap_q  <= prb_cap;
                    addr_q <= prb_addr;
                    st     <= ST_LOOKUP;
                end
                ST_LOOKUP: begin
                    vd_q   <= vd;
                    beat_q <= '0;
                    st     <= vd.has_data ? ST_FETCH : ST_ACK;
                end
                ST_FETCH: begin
                    data_q <= data_rd_data;
                    st     <= ST_SEND;
                end
                ST_SEND: if (ack_ready) begin
                    if (at_last) begin
                        st <= ST_DONE;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        st     <= ST_FETCH;
                    end
                end
                ST_ACK:  if (ack_ready) st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        at_last      = (beat_q == LAST_BEAT);
        prb_ready    = (st == ST_IDLE);
        busy         = !prb_ready;
        meta_rd_en   = prb_ready && prb_valid;
        meta_rd_addr = prb_addr;

        data_rd_en   = ((st == ST_LOOKUP) && vd.has_data) ||
                       ((st == ST_SEND) && ack_ready && !at_last);
        data_rd_addr = {addr_q, (st == ST_LOOKUP) ? '0 : beat_q + 1'b1};

        ack_valid    = (st == ST_SEND) || (st == ST_ACK);
        ack_has_data = (st == ST_SEND);
        ack_last     = (st == ST_SEND) ? at_last : (st == ST_ACK);
        ack_old_perm = vd_q.old_perm;
        ack_new_perm = vd_q.new_perm;
        ack_addr     = addr_q;
        ack_data     = (st == ST_SEND) ? data_q : '0;

        meta_wr_en    = (st == ST_DONE) && vd_q.wr;
        meta_wr_addr  = addr_q;
        meta_wr_perm  = vd_q.new_perm;
        meta_wr_dirty = vd_q.new_dirty;
    end

    // R7: a stalled beat holds its contents
    a_r7_beat_hold: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !ack_ready |=> ack_valid && $stable(ack_data) &&
                                   $stable(ack_last) && $stable(ack_has_data));

    // R7: nothing follows the final beat of a response
    a_r7_single_burst: assert property (@(posedge clk) disable iff (rst)
        ack_valid && ack_ready && ack_last |=> !ack_valid);

    // R8: metadata is committed the cycle after the final beat is taken
    a_r8_wr_after_final: assert property (@(posedge clk) disable iff (rst)
        meta_wr_en |-> $past(ack_valid && ack_ready && ack_last));

    // R9: a committed line is never left dirty by a probe that lowered it
    a_r9_wr_clean: assert property (@(posedge clk) disable iff (rst)
        meta_wr_en |-> !meta_wr_dirty);

    // R10: no lookup overlaps an outstanding response
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !meta_rd_en);

endmodule

// File: rtl/prb_resp.sv
module prb_resp
    import prb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BEATS  = 4,
    parameter int DATA_W = 32,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_exclusive,
    input  logic                     prb_valid,
    output logic                     prb_ready,
    input  logic [1:0]               prb_kind,
    input  logic [1:0]               prb_cap,
    input  logic [ADDR_W-1:0]        prb_addr,
    output logic                     busy,
    output logic                     meta_rd_en,
    output logic [ADDR_W-1:0]        meta_rd_addr,
    input  logic [1:0]               meta_rd_perm,
    input  logic                     meta_rd_dirty,
    output logic                     data_rd_en,
    output logic [ADDR_W+BEAT_W-1:0] data_rd_addr,
    input  logic [DATA_W-1:0]        data_rd_data,
    output logic                     ack_valid,
    input  logic                     ack_ready,
    output logic                     ack_has_data,
    output logic                     ack_last,
    output logic [1:0]               ack_old_perm,
    output logic [1:0]               ack_new_perm,
    output logic [ADDR_W-1:0]        ack_addr,
    output logic [DATA_W-1:0]        ack_data,
    output logic                     meta_wr_en,
    output logic [ADDR_W-1:0]        meta_wr_addr,
    output logic [1:0]               meta_wr_perm,
    output logic                     meta_wr_dirty
);

    prb_kind_e kind_q;
    perm_e     cap_q;
    verdict_t  vd;
    perm_e     old_p;
    perm_e     new_p;
    perm_e     wr_p;

    prb_policy u_policy (
        .clk       (clk),
        .rst       (rst),
        .excl      (cfg_exclusive),
        .kind      (kind_q),
        .cap       (cap_q),
        .cur_perm  (perm_e'(meta_rd_perm)),
        .cur_dirty (meta_rd_dirty),
        .vd        (vd)
    );

    prb_seq #(
        .ADDR_W (ADDR_W),
        .BEATS  (BEATS),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .prb_valid     (prb_valid),
        .prb_ready     (prb_ready),
        .prb_kind      (prb_kind_e'(prb_kind)),
        .prb_cap       (perm_e'(prb_cap)),
        .prb_addr      (prb_addr),
        .busy          (busy),
        .meta_rd_en    (meta_rd_en),
        .meta_rd_addr  (meta_rd_addr),
        .kind_q        (kind_q),
        .cap_q         (cap_q),
        .vd            (vd),
        .data_rd_en    (data_rd_en),
        .data_rd_addr  (data_rd_addr),
        .data_rd_data  (data_rd_data),
        .ack_valid     (ack_valid),
        .ack_ready     (ack_ready),
        .ack_has_data  (ack_has_data),
        .ack_last      (ack_last),
        .ack_old_perm  (old_p),
        .ack_new_perm  (new_p),
        .ack_addr      (ack_addr),
        .ack_data      (ack_data),
        .meta_wr_en    (meta_wr_en),
        .meta_wr_addr  (meta_wr_addr),
        .meta_wr_perm  (wr_p),
        .meta_wr_dirty (meta_wr_dirty)
    );

    assign ack_old_perm = old_p;
    assign ack_new_perm = new_p;
    assign meta_wr_perm = wr_p;

endmodule

// File: tb/prb_resp_tb_top.sv
module prb_resp_tb_top;

    localparam int ADDR_W = 8;
    localparam int BEATS  = 4;
    localparam int DATA_W = 32;
    localparam int BEAT_W = $clog2(BEATS);

    typedef struct packed {
        logic       excl;
        logic [1:0] kind;
        logic [1:0] cap;
        logic [1:0] perm;
        logic       dirty;
        logic       e_data;
        logic [1:0] e_new;
        logic       e_dirty;
        logic       e_wr;
        logic [3:0] rq;
        logic       stall;
    } vec_t;

    // excl kind cap perm dirty | data new dirty wr | req stall
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 4'd1, 1'b0},
        '{1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 4'd1, 1'b1},
        '{1'b0, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 4'd1, 1'b0},
        '{1'b0, 2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd1, 1'b1},
        '{1'b1, 2'd1, 2'd1, 2'd2, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 4'd2, 1'b1},
        '{1'b1, 2'd1, 2'd0, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 4'd2, 1'b0},
        '{1'b1, 2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 4'd3, 1'b1},
        '{1'b1, 2'd2, 2'd0, 2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 4'd3, 1'b0},
        '{1'b1, 2'd2, 2'd1, 2'd2, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 4'd4, 1'b0},
        '{1'b1, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd4, 1'b1},
        '{1'b1, 2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 4'd4, 1'b1},
        '{1'b0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd5, 1'b0},
        '{1'b1, 2'd1, 2'd2, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 4'd5, 1'b1},
        '{1'b0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 4'd5, 1'b0}
    };

    logic clk = 1'b0;
    logic rst;
    logic cfg_exclusive;
    logic prb_valid;
    logic prb_ready;
    logic [1:0] prb_kind;
    logic [1:0] prb_cap;
    logic [ADDR_W-1:0] prb_addr;
    logic busy;
    logic meta_rd_en;
    logic [ADDR_W-1:0] meta_rd_addr;
    logic [1:0] meta_rd_perm;
    logic meta_rd_dirty;
    logic data_rd_en;
    logic [ADDR_W+BEAT_W-1:0] data_rd_addr;
    logic [DATA_W-1:0] data_rd_data;
    logic ack_valid;
    logic ack_ready;
    logic ack_has_data;
    logic ack_last;
    logic [1:0] ack_old_perm;
    logic [1:0] ack_new_perm;
    logic [ADDR_W-1:0] ack_addr;
    logic [DATA_W-1:0] ack_data;
    logic meta_wr_en;
    logic [ADDR_W-1:0] meta_wr_addr;
    logic [1:0] meta_wr_perm;
    logic meta_wr_dirty;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prb_resp #(.ADDR_W(ADDR_W), .BEATS(BEATS), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_exclusive(cfg_exclusive),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind),
        .prb_cap(prb_cap), .prb_addr(prb_addr), .busy(busy),
        .meta_rd_en(meta_rd_en), .meta_rd_addr(meta_rd_addr),
        .meta_rd_perm(meta_rd_perm), .meta_rd_dirty(meta_rd_dirty),
        .data_rd_en(data_rd_en), .data_rd_addr(data_rd_addr),
        .data_rd_data(data_rd_data), .ack_valid(ack_valid), .ack_ready(ack_ready),
        .ack_has_data(ack_has_data), .ack_last(ack_last),
        .ack_old_perm(ack_old_perm), .ack_new_perm(ack_new_perm),
        .ack_addr(ack_addr), .ack_data(ack_data), .meta_wr_en(meta_wr_en),
        .meta_wr_addr(meta_wr_addr), .meta_wr_perm(meta_wr_perm),
        .meta_wr_dirty(meta_wr_dirty)
    );

    // Bench-side metadata and data stores, both one-cycle synchronous reads.
    logic [2:0] meta_mem [2**ADDR_W];
    logic seed_en = 1'b0;
    logic [ADDR_W-1:0] seed_addr = '0;
    logic [2:0] seed_val = '0;

    function automatic logic [DATA_W-1:0] pat(logic [ADDR_W+BEAT_W-1:0] a);
        return 32'hC0DE_0000 ^ (DATA_W'(a) * 32'd2654435);
    endfunction

    always @(posedge clk) begin
        if (seed_en) meta_mem[seed_addr] <= seed_val;
        else if (meta_wr_en) meta_mem[meta_wr_addr] <= {meta_wr_perm, meta_wr_dirty};
        if (meta_rd_en) {meta_rd_perm, meta_rd_dirty} <= meta_mem[meta_rd_addr];
        if (data_rd_en) data_rd_data <= pat(data_rd_addr);
    end

    function automatic string rtag(logic [3:0] rq);
        case (rq)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Results of one collected response
    int got_beats, got_data, got_old, got_new, wr_cnt, wr_perm, wr_dirty, wr_addr;
    int bad_data, bad_last, bad_hold, wr_gap, busy_bad;

    task automatic seed(input logic [ADDR_W-1:0] a, input logic [2:0] v);
        @(negedge clk);
        seed_en = 1'b1; seed_addr = a; seed_val = v;
        @(negedge clk);
        seed_en = 1'b0;
    endtask

    // Offers one probe and collects the whole response until idle.
    task automatic run_probe(input logic [1:0] kind, input logic [1:0] cap,
                             input logic [ADDR_W-1:0] a, input logic stall,
                             input logic hold_next);
        logic was_stalled;
        logic [DATA_W-1:0] held_d;
        logic held_l;
        int since_last;
        got_beats = 0; got_data = -1; got_old = -1; got_new = -1;
        wr_cnt = 0; wr_perm = -1; wr_dirty = -1; wr_addr = -1;
        bad_data = 0; bad_last = 0; bad_hold = 0; wr_gap = 0; busy_bad = 0;
        was_stalled = 1'b0; held_d = '0; held_l = 1'b0; since_last = 99;
        @(negedge clk);
        prb_valid = 1'b1; prb_kind = kind; prb_cap = cap; prb_addr = a;
        @(negedge clk);
        if (!hold_next) prb_valid = 1'b0;
        for (int n = 0; n < 80; n++) begin
            ack_ready = stall ? n[0] : 1'b1;
            #1;
            if (prb_ready) break;
            if (!busy || meta_rd_en) busy_bad++;
            since_last++;
            if (meta_wr_en) begin
                wr_cnt++; wr_perm = meta_wr_perm; wr_dirty = meta_wr_dirty;
                wr_addr = meta_wr_addr;
                if (since_last != 1) wr_gap++;
            end
            if (ack_valid) begin
                if (was_stalled && (ack_data != held_d || ack_last != held_l)) bad_hold++;
                if (ack_ready) begin
                    got_data = ack_has_data; got_old = ack_old_perm; got_new = ack_new_perm;
                    if (ack_has_data) begin
                        if (ack_data != pat({a, BEAT_W'(got_beats)})) bad_data++;
                        if (ack_last != (got_beats == BEATS-1)) bad_last++;
                    end else if (!ack_last) bad_last++;
                    if (ack_addr != a) bad_data++;
                    got_beats++;
                    if (ack_last) since_last = 0;
                    was_stalled = 1'b0;
                end else begin
                    was_stalled = 1'b1; held_d = ack_data; held_l = ack_last;
                end
            end
            @(negedge clk);
        end
        ack_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R10: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_exclusive = 1'b0; prb_valid = 1'b0; prb_kind = '0;
        prb_cap = '0; prb_addr = '0; ack_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle after reset
        check(prb_ready == 1'b1, "R11", "prb_ready after reset", prb_ready, 1);
        check(busy == 1'b0, "R11", "busy after reset", busy, 0);
        check(ack_valid == 1'b0, "R11", "ack_valid after reset", ack_valid, 0);
        check(meta_wr_en == 1'b0, "R11", "meta_wr_en after reset", meta_wr_en, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [ADDR_W-1:0] a;
            int exp_beats;
            v = VECS[i];
            a = ADDR_W'(8'h11 + i * 7);
            cfg_exclusive = v.excl;
            seed(a, {v.perm, v.dirty});
            run_probe(v.kind, v.cap, a, v.stall, 1'b0);
            exp_beats = v.e_data ? BEATS : 1;
            check(got_data == int'(v.e_data), rtag(v.rq), "data choice", got_data, v.e_data);
            check(got_beats == exp_beats, "R7", "beat count", got_beats, exp_beats);
            check(bad_data == 0, "R7", "beat data/addr errors", bad_data, 0);
            check(bad_last == 0, "R7", "last flag errors", bad_last, 0);
            check(bad_hold == 0, "R7", "stall hold errors", bad_hold, 0);
            check(got_old == int'(v.perm), "R6", "old perm", got_old, v.perm);
            check(got_new == int'(v.e_new), "R6", "new perm", got_new, v.e_new);
            check(busy_bad == 0, "R10", "busy/lookup while answering", busy_bad, 0);
            if (v.e_wr) begin
                check(wr_cnt == 1, "R8", "meta write count", wr_cnt, 1);
                check(wr_gap == 0, "R8", "meta write timing", wr_gap, 0);
                check(wr_addr == int'(a), "R8", "meta write addr", wr_addr, a);
                check(wr_perm == int'(v.e_new), "R8", "meta write perm", wr_perm, v.e_new);
                check(wr_dirty == int'(v.e_dirty), "R9", "meta write dirty", wr_dirty, v.e_dirty);
            end else begin
                check(wr_cnt == 0, "R5", "no meta write", wr_cnt, 0);
            end
        end

        // R10: a second probe held on the input waits, then sees the downgrade.
        cfg_exclusive = 1'b0;
        seed(8'hE0, {2'd2, 1'b1});
        run_probe(2'd0, 2'd0, 8'hE0, 1'b1, 1'b1);
        check(busy_bad == 0, "R10", "held probe looked up early", busy_bad, 0);
        check(got_beats == BEATS, "R10", "first probe beats", got_beats, BEATS);
        check(wr_cnt == 1 && wr_perm == 0, "R10", "first probe write perm", wr_perm, 0);
        // prb_valid still high: the second probe is taken now
        @(negedge clk);
        prb_valid = 1'b0;
        check(busy == 1'b1, "R10", "second probe accepted", busy, 1);
        for (int n = 0; n < 20 && !ack_valid; n++) @(negedge clk);
        ack_ready = 1'b1;
        #1;
        check(ack_valid && !ack_has_data, "R10", "second probe dataless", ack_has_data, 0);
        check(ack_old_perm == 2'd0, "R10", "second probe sees none", ack_old_perm, 0);
        @(negedge clk);
        ack_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(prb_ready == 1'b1, "R10", "idle after second probe", prb_ready, 1);

        // R11: reset in the middle of a response returns to idle
        cfg_exclusive = 1'b1;
        seed(8'hE4, {2'd2, 1'b0});
        @(negedge clk);
        prb_valid = 1'b1; prb_kind = 2'd1; prb_cap = 2'd0; prb_addr = 8'hE4;
        @(negedge clk);
        prb_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(prb_ready && !ack_valid && !meta_wr_en, "R11", "idle after mid reset",
              {prb_ready, ack_valid, meta_wr_en}, 3'b100);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule